// File: doc/BRIEF.md
# Bus Access Counting Test Target

This block is a bus-side test target for checking whether writes arrive where software intends them to. It has two byte-wide ports: one decodes a 4096-byte memory window and the other a 256-byte I/O window. Both feed one shared set of control state. Software picks one of six test profiles by writing a number to byte 0 of either port. The port that carries the selecting write fixes which half of the profile set is chosen.

Once a profile is active, the block counts writes that land on that profile's trigger address. For wildcard profiles any such write counts. For data-match profiles a write counts only when it is one byte wide and carries the profile's match byte. Software checks the result by reading the profile's header byte by byte. The header holds the profile's configuration, the live 32-bit hit count in little-endian order and an ASCII name. Each port returns read data one cycle after the access.

Top module: `bus_hit_target`

## Requirements
- R1: A write to address 0 on either port first deselects the active profile. If the written byte is below 3, it then selects profile index = type*3 + byte, where the memory port is type 0 and the I/O port is type 1. A byte of 3 or more leaves no profile active.
- R2: Selecting a profile sets the hit count to zero.
- R3: Header bytes of the active profile i, by address: 0 holds i; 1 holds 1; 4..7 hold the trigger offset, little-endian, which is 2048+i for i<3 and 128+i for i>=3; 8 holds the match byte, 0xFA for i=2 and i=5 and 0xCE for the others; 2, 3, 9, 10 and 11 hold 0.
- R4: Starting at address 16, the header holds the name "<mmio|portio>-<no-eventfd|wildcard-eventfd|datamatch-eventfd>". The first part is mmio for i<3. The second part is picked by i mod 3. A read returns 0 when address + size is at least 17 + name length.
- R5: While no profile is active, every read returns 0 and writes to nonzero addresses have no effect.
- R6: For profiles with i mod 3 not equal to 2, a write on either port whose address equals the active trigger offset adds 1 to the count, whatever its data and size. A write to any other nonzero address leaves the count unchanged.
- R7: For profiles 2 and 5, a write to the trigger offset counts only when size is 1 and the data is 0xFA.
- R8: Header bytes 12..15 show the current count, little-endian, including every hit since the profile was selected. The count wraps modulo 2^32.
- R9: When both ports present an access in the same cycle, only the memory-port access takes effect. The I/O access is discarded, and its read data in the next cycle is 0.
- R10: Read data appears on a port's rdata in the cycle after the read. In every cycle that does not follow a read accepted on that port, that port's rdata is 0.
- R11: Reset leaves no profile active and both rdata outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_valid | input | 1 | Memory-port access request |
| m_we | input | 1 | Memory-port write enable |
| m_addr | input | 12 | Memory-port byte address |
| m_wdata | input | 8 | Memory-port write data |
| m_size | input | 3 | Memory-port access size in bytes |
| m_rdata | output | 8 | Memory-port read data, one cycle after the read |
| p_valid | input | 1 | I/O-port access request |
| p_we | input | 1 | I/O-port write enable |
| p_addr | input | 8 | I/O-port byte address |
| p_wdata | input | 8 | I/O-port write data |
| p_size | input | 3 | I/O-port access size in bytes |
| p_rdata | output | 8 | I/O-port read data, one cycle after the read |

## Verification
Two things can fall in the same cycle: an access on the memory port and an access on the I/O port. Both act on the single selection and count state. The bench drives both ports in one cycle in three combinations. In the first, both ports write a selection at once, and the header read afterwards must show the memory port's choice. In the second, the memory port reads while the I/O port writes the active trigger, and the count must stay unchanged. In the third, both ports read at once, and the I/O rdata must be zero while the memory rdata carries the header byte.

// File: rtl/bus_hit_target.sv
module bus_hit_target #(
  parameter int MEM_AW   = 12,
  parameter int IO_AW    = 8,
  parameter int MEM_BASE = 2048,
  parameter int IO_BASE  = 128,
  parameter int SZ_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_valid,
  input  logic              m_we,
  input  logic [MEM_AW-1:0] m_addr,
  input  logic [7:0]        m_wdata,
  input  logic [SZ_W-1:0]   m_size,
  output logic [7:0]        m_rdata,
  input  logic              p_valid,
  input  logic              p_we,
  input  logic [IO_AW-1:0]  p_addr,
  input  logic [7:0]        p_wdata,
  input  logic [SZ_W-1:0]   p_size,
  output logic [7:0]        p_rdata
);
  localparam int PROF = 3;
  localparam int IW   = $clog2(2 * PROF);
  localparam int CW   = 32;
  localparam logic [7:0] HIT_BYTE  = 8'hFA;
  localparam logic [7:0] MISS_BYTE = 8'hCE;
  localparam logic [39:0]  PFX_M = "mmio-";
  localparam logic [55:0]  PFX_P = "portio-";
  localparam logic [79:0]  SUF0  = "no-eventfd";
  localparam logic [127:0] SUF1  = "wildcard-eventfd";
  localparam logic [135:0] SUF2  = "datamatch-eventfd";

  logic          act;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;

  wire use_p   = p_valid && !m_valid;
  wire a_valid = m_valid || p_valid;

  logic              a_we;
  logic [MEM_AW-1:0] a_addr;
  logic [7:0]        a_wdata;
  logic [SZ_W-1:0]   a_size;

  always_comb begin
    if (use_p) begin
      a_we    = p_we;
      a_addr  = MEM_AW'(p_addr);
      a_wdata = p_wdata;
      a_size  = p_size;
    end else begin
      a_we    = m_we;
      a_addr  = m_addr;
      a_wdata = m_wdata;
      a_size  = m_size;
    end
  end

  wire          is_io = idx >= IW'(PROF);
  wire [IW-1:0] prof  = is_io ? idx - IW'(PROF) : idx;
  wire          dm    = prof == IW'(2);
  wire [CW-1:0] trig  = CW'(is_io ? IO_BASE : MEM_BASE) + CW'(idx);
  wire [7:0]    mbyte = dm ? HIT_BYTE : MISS_BYTE;

  wire wr  = a_valid && a_we;
  wire sel = wr && a_addr == '0;
  wire ok  = a_wdata < 8'd3;
  wire qual = !dm || (a_size == SZ_W'(1) && a_wdata == HIT_BYTE);
  wire hit = wr && a_addr != '0 && act && CW'(a_addr) == trig && qual;
  wire [IW-1:0] new_idx = IW'(use_p ? PROF : 0) + IW'(a_wdata[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      idx <= '0;
      cnt <= '0;
    end else if (sel) begin
      act <= ok;
      if (ok) begin
        idx <= new_idx;
        cnt <= '0;
      end
    end else if (hit) begin
      cnt <= cnt + 1'b1;
    end
  end

  function automatic logic [7:0] name_ch(input logic io, input int pr, input int k);
    int pl;
    int j;
    pl = io ? 7 : 5;
    if (k < pl) begin
      if (io) return PFX_P[8*(6-k) +: 8];
      return PFX_M[8*(4-k) +: 8];
    end
    j = k - pl;
    case (pr)
      0: if (j < 10) return SUF0[8*(9-j) +: 8];
      1: if (j < 16) return SUF1[8*(15-j) +: 8];
      default: if (j < 17) return SUF2[8*(16-j) +: 8];
    endcase
    return 8'h00;
  endfunction

  int plen, slen, hlen, a;
  logic [7:0] hb, rd_val;

  always_comb begin
    plen = is_io ? 7 : 5;
    case (prof)
      IW'(0):  slen = 10;
      IW'(1):  slen = 16;
      default: slen = 17;
    endcase
    hlen = 17 + plen + slen;
    a = int'(a_addr);
    hb = 8'h00;
    if (a == 0)                 hb = 8'(idx);
    else if (a == 1)            hb = 8'h01;
    else if (a >= 4 && a <= 7)  hb = trig[8*(a-4) +: 8];
    else if (a == 8)            hb = mbyte;
    else if (a >= 12 && a <= 15) hb = cnt[8*(a-12) +: 8];
    else if (a >= 16 && a < hlen) hb = name_ch(is_io, int'(prof), a - 16);
    rd_val = (act && a + int'(a_size) < hlen) ? hb : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rdata <= '0;
      p_rdata <= '0;
    end else begin
      m_rdata <= (m_valid && !m_we) ? rd_val : 8'h00;
      p_rdata <= (use_p && !p_we) ? rd_val : 8'h00;
    end
  end
endmodule

module bus_hit_target_chk #(
  parameter int MEM_AW = 12,
  parameter int IO_AW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              m_valid,
  input logic              m_we,
  input logic [MEM_AW-1:0] m_addr,
  input logic [7:0]        m_wdata,
  input logic [7:0]        m_rdata,
  input logic              p_valid,
  input logic              p_we,
  input logic [IO_AW-1:0]  p_addr,
  input logic [7:0]        p_wdata,
  input logic [7:0]        p_rdata,
  input logic              act,
  input logic [2:0]        idx,
  input logic [31:0]       cnt
);
  assert_sel_mem_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(m_valid && m_we && m_addr == '0 && m_wdata < 8'd3))
    |-> (act && idx == $past(m_wdata[2:0])));

  assert_sel_io_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(p_valid && !m_valid && p_we && p_addr == '0 && p_wdata < 8'd3))
    |-> (act && idx == 3'd3 + $past(p_wdata[2:0])));

  assert_desel_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(m_valid && m_we && m_addr == '0 && m_wdata >= 8'd3))
    |-> !act);

  assert_sel_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(m_valid && m_we && m_addr == '0 && m_wdata < 8'd3))
    |-> cnt == 32'd0);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 32'd1 || cnt == 32'd0));

  assert_idle_read_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!act && m_valid && !m_we)) |-> m_rdata == 8'h00);

  assert_io_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(m_valid && p_valid)) |-> p_rdata == 8'h00);

  assert_quiet_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(m_valid && !m_we)) |-> m_rdata == 8'h00);

  assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!act && m_rdata == 8'h00 && p_rdata == 8'h00));
endmodule

bind bus_hit_target bus_hit_target_chk #(.MEM_AW(MEM_AW), .IO_AW(IO_AW)) u_chk (.*);

// File: tb/test_bus_hit_target.sv
module test_bus_hit_target;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_valid = 0, m_we = 0, p_valid = 0, p_we = 0;
  logic [11:0] m_addr = '0;
  logic [7:0]  p_addr = '0;
  logic [7:0]  m_wdata = '0, p_wdata = '0;
  logic [2:0]  m_size = 3'd1, p_size = 3'd1;
  logic [7:0]  m_rdata, p_rdata;

  always #5 clk = ~clk;

  bus_hit_target i_bus_hit_target (
    .clk(clk), .rst(rst),
    .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_size(m_size), .m_rdata(m_rdata),
    .p_valid(p_valid), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_size(p_size), .p_rdata(p_rdata)
  );

  int n_chk = 0, n_err = 0;
  bit md_act = 0;
  int md_idx = 0;
  longint unsigned md_cnt = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic string name_of(input int t);
    string pre, suf;
    pre = (t < 3) ? "mmio-" : "portio-";
    case (t % 3)
      0: suf = "no-eventfd";
      1: suf = "wildcard-eventfd";
      default: suf = "datamatch-eventfd";
    endcase
    return {pre, suf};
  endfunction

  function automatic int trig_of(input int t);
    return (t < 3 ? 2048 : 128) + t;
  endfunction

  function automatic int expv(input int a, input int sz);
    string nm;
    int hl, tr;
    if (!md_act) return 0;
    nm = name_of(md_idx);
    hl = 17 + nm.len();
    if (a + sz >= hl) return 0;
    tr = trig_of(md_idx);
    if (a == 0) return md_idx;
    if (a == 1) return 1;
    if (a >= 4 && a <= 7) return (tr >> (8 * (a - 4))) & 255;
    if (a == 8) return (md_idx % 3 == 2) ? 8'hFA : 8'hCE;
    if (a >= 12 && a <= 15) return int'((md_cnt >> (8 * (a - 12))) & 255);
    if (a >= 16) return int'(nm[a - 16]);
    return 0;
  endfunction

  function automatic void model_wr(input bit io, input int addr, input int data, input int sz);
    if (addr == 0) begin
      md_act = 0;
      if (data < 3) begin
        md_act = 1;
        md_idx = (io ? 3 : 0) + data;
        md_cnt = 0;
      end
    end else if (md_act && addr == trig_of(md_idx) &&
                 (md_idx % 3 != 2 || (sz == 1 && data == 8'hFA))) begin
      md_cnt = (md_cnt + 1) & 64'hFFFF_FFFF;
    end
  endfunction

  task automatic access(input bit io, input bit we, input int addr, input int data,
                        input int sz, output int rd);
    @(negedge clk);
    if (io) begin
      p_valid = 1; p_we = we; p_addr = 8'(addr); p_wdata = 8'(data); p_size = 3'(sz);
    end else begin
      m_valid = 1; m_we = we; m_addr = 12'(addr); m_wdata = 8'(data); m_size = 3'(sz);
    end
    @(negedge clk);
    rd = io ? int'(p_rdata) : int'(m_rdata);
    m_valid = 0; p_valid = 0; m_we = 0; p_we = 0;
  endtask

  task automatic wr(input bit io, input int addr, input int data, input int sz);
    int rd;
    model_wr(io, addr, data, sz);
    access(io, 1, addr, data, sz, rd);
    chk("R10 rdata after write", rd, 0);
  endtask

  task automatic rd_chk(input string tag, input bit io, input int addr, input int sz);
    int rd;
    access(io, 0, addr, 0, sz, rd);
    chk(tag, rd, expv(addr, sz));
  endtask

  task automatic dual(input bit mwe, input int maddr, input int mdata,
                      input bit pwe, input int paddr, input int pdata,
                      output int mrd, output int prd);
    @(negedge clk);
    m_valid = 1; m_we = mwe; m_addr = 12'(maddr); m_wdata = 8'(mdata); m_size = 3'd1;
    p_valid = 1; p_we = pwe; p_addr = 8'(paddr); p_wdata = 8'(pdata); p_size = 3'd1;
    @(negedge clk);
    mrd = int'(m_rdata); prd = int'(p_rdata);
    m_valid = 0; p_valid = 0; m_we = 0; p_we = 0;
  endtask

  task automatic read_count(input string tag);
    for (int a = 12; a < 16; a++) rd_chk(tag, 0, a, 1);
  endtask

  initial begin
    #(10 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int mrd, prd;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R11 m_rdata at reset", int'(m_rdata), 0);
    chk("R11 p_rdata at reset", int'(p_rdata), 0);
    for (int a = 0; a < 20; a++) rd_chk("R11 read after reset", 0, a, 1);
    wr(0, 2048, 8'hCE, 1);
    for (int a = 0; a < 20; a++) rd_chk("R5 inactive read", 1, a, 1);

    // R1 R3 R4: selection and full header sweep on both ports
    for (int io = 0; io < 2; io++) begin
      for (int v = 0; v < 5; v++) begin
        wr(io[0], 0, v, 1);
        for (int a = 0; a < 48; a++) rd_chk("R1 R3 R4 header", io[0], a, 1);
        for (int a = 36; a < 44; a++) rd_chk("R4 header end size2", 0, a, 2);
        for (int a = 34; a < 44; a++) rd_chk("R4 header end size4", 1, a, 4);
      end
    end

    // R6 R7 R8: counting per profile
    for (int t = 0; t < 6; t++) begin
      int tr = trig_of(t);
      wr(t >= 3, 0, t % 3, 1);
      read_count("R2 count cleared");
      wr(0, tr, 8'hFA, 1);  read_count("R6 R7 fa size1");
      wr(0, tr, 8'h00, 1);  read_count("R6 R7 other data");
      wr(0, tr, 8'hFA, 2);  read_count("R6 R7 size2");
      wr(0, tr + 1, 8'hFA, 1); read_count("R6 off trigger");
      if (t >= 3) begin
        wr(1, tr, 8'hFA, 1); read_count("R6 R7 io port trigger");
        wr(1, tr, 8'h12, 4); read_count("R6 R7 io port wide");
      end
      wr(0, 5, 8'hFA, 1);   read_count("R6 unrelated addr");
      wr(0, tr, 8'hFA, 1);  rd_chk("R8 live count", 0, 12, 1);
      wr(t >= 3, 0, t % 3, 1); read_count("R2 reselect clears");
    end

    // R8: carry across count bytes
    wr(1, 0, 1, 1);
    for (int n = 0; n < 300; n++) wr(1, trig_of(4), n, 1 + n % 3);
    read_count("R8 count 300");

    // R9: simultaneous accesses
    model_wr(0, 0, 1, 1);
    dual(1, 0, 1, 1, 0, 2, mrd, prd);
    chk("R9 sel both R10", mrd, 0);
    rd_chk("R9 mem selection wins", 0, 0, 1);
    wr(0, 0, 2, 1);
    wr(0, 0, 2 - 2 + 0, 1);
    wr(1, 0, 1, 1);
    wr(1, trig_of(4), 8'h33, 1);
    dual(0, 12, 0, 1, trig_of(4), 8'h44, mrd, prd);
    chk("R9 mem read during io write", mrd, expv(12, 1));
    read_count("R9 io write dropped");
    dual(0, 0, 0, 0, 0, 0, mrd, prd);
    chk("R9 mem read data", mrd, expv(0, 1));
    chk("R9 io read zero", prd, 0);

    // R1: deselect by value >= 3, R5: writes ignored while idle
    wr(0, 0, 3, 1);
    rd_chk("R1 deselect", 0, 0, 1);
    wr(1, 0, 200, 1);
    wr(1, trig_of(4), 1, 1);
    for (int a = 0; a < 16; a++) rd_chk("R5 idle after deselect", 1, a, 1);

    // R11: reset mid-test
    wr(0, 0, 1, 1);
    wr(0, trig_of(1), 0, 1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    md_act = 0;
    for (int a = 0; a < 16; a++) rd_chk("R11 reset deselects", 0, a, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule